// File: doc/BRIEF.md
# Stride-Based Data Prefetcher

This block runs ahead of instruction decode and warms the data cache for loads that walk memory at a regular step. Every cycle the front end presents the fetch address that the branch predictor expects next. The block compares that address with the instruction-address tags held in a small fully associative table. Each entry of the table describes one static load: the data address it used last, the step between its last two data addresses, and a two-bit confidence counter. When a confident entry matches, the block adds the step to the last address and places the result in a prefetch FIFO.

The FIFO drains through a touch port into the data cache. A touch asks the cache to look up a line so that a miss starts early. No data comes back. When the cache reports that a touch missed, the block raises a one-cycle request to the next memory level for that address. The table learns from executed loads. A known load updates its step and its confidence. An unknown load takes a slot chosen in round-robin order.

Top module: `stride_prefetcher`

## Requirements
- R1: While rst_ni is low and after it is released, the FIFO is empty, touch_valid_o and nl_req_o are 0, and every table slot is invalid. The round-robin slot pointer starts at slot 0.
- R2: In a cycle with fetch_valid_i high, the table is searched with fetch_pc_i. If the tag matches and the entry's confidence is 2 or more, last address + stride, taken modulo 2^ADDR_W, is pushed. touch_valid_o and touch_addr_o show a push into an empty FIFO right after that clock edge. The search sees the table as it was before any training in the same cycle.
- R3: When train_valid_i is high and train_pc_i matches a valid entry, that entry's stride becomes train_addr_i minus its last address (two's complement, ADDR_W bits). Its last address becomes train_addr_i. A negative stride therefore predicts descending addresses.
- R4: Confidence is a 2-bit saturating counter. It goes up by 1 when the new stride equals the stored one and down by 1 otherwise, stopping at 3 and at 0.
- R5: A training load with no matching tag takes the slot under the round-robin pointer with stride 0 and confidence 0, and the pointer then advances, wrapping after ENTRIES-1. The old contents of that slot are lost, and a fetch with the evicted address no longer prefetches.
- R6: The FIFO hands out addresses oldest first. An entry leaves on a cycle with touch_valid_o and touch_ready_i both high. While touch_ready_i is low, touch_valid_o stays high and touch_addr_o does not change.
- R7: A prefetch that arrives while the FIFO already holds QDEPTH entries is dropped, even if an entry leaves in the same cycle.
- R8: A prefetch equal to the most recently enqueued address still in a non-empty FIFO is not enqueued.
- R9: A touch handshake with touch_miss_i high makes nl_req_o high for exactly the next cycle, with nl_addr_o equal to the touched address. A handshake with touch_miss_i low raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Predicted fetch address is valid this cycle |
| fetch_pc_i | input | PC_W | Predicted instruction fetch address |
| train_valid_i | input | 1 | An executed load reports its address |
| train_pc_i | input | PC_W | Instruction address of the executed load |
| train_addr_i | input | ADDR_W | Data address of the executed load |
| touch_valid_o | output | 1 | A cache-touch request is pending |
| touch_addr_o | output | ADDR_W | Address to touch |
| touch_ready_i | input | 1 | Cache accepts the touch this cycle |
| touch_miss_i | input | 1 | The accepted touch missed in the cache |
| nl_req_o | output | 1 | Fetch request to the next memory level |
| nl_addr_o | output | ADDR_W | Address of the next-level fetch |

## Verification
One load is trained through a table of vectors that covers first sighting, a change of step, a steady positive step, an abrupt jump and a steady negative step. Comparing whether a touch appears after each step separates correct confidence counting from an off-by-one threshold or a missing saturation. The negative-step vectors expose any unsigned arithmetic in the stride. Directed sequences then repeat one fetch address, alternate two trained loads past the FIFO depth, and overflow the table with new loads. These separate tail-duplicate suppression from general de-duplication, dropping on full from overwriting, and round-robin eviction from fixed-slot replacement. Touches that hit and touches that miss show whether the next-level request follows only misses.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int unsigned CONF_W = 2;
  localparam int unsigned CONF_FIRE = 2;
  localparam int unsigned CONF_MAX = (1 << CONF_W) - 1;

  typedef logic [CONF_W-1:0] conf_t;

  function automatic conf_t conf_step(conf_t c, logic up);
    conf_t r;
    if (up) r = (c == conf_t'(CONF_MAX)) ? c : c + conf_t'(1);
    else    r = (c == '0) ? c : c - conf_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/spf_table.sv
module spf_table
  import spf_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic              tr_valid_i,
  input  logic [PC_W-1:0]   tr_pc_i,
  input  logic [ADDR_W-1:0] tr_addr_i,
  output logic              lk_fire_o,
  output logic [ADDR_W-1:0] lk_addr_o
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              vld_q    [ENTRIES];
  logic [PC_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0] last_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  conf_t             conf_q   [ENTRIES];
  logic [IDX_W-1:0]  rr_q;

  logic [ENTRIES-1:0] lk_hit;
  logic [ENTRIES-1:0] tr_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hit[g] = vld_q[g] && (tag_q[g] == lk_pc_i);
    assign tr_hit[g] = vld_q[g] && (tag_q[g] == tr_pc_i);
  end

  // lowest matching slot wins; training keeps tags unique
  always_comb begin
    lk_fire_o = 1'b0;
    lk_addr_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_hit[i]) begin
        lk_fire_o = lk_valid_i && (conf_q[i] >= conf_t'(CONF_FIRE));
        lk_addr_o = last_q[i] + stride_q[i];
      end
    end
  end

  logic tr_any;
  logic alloc;
  assign tr_any = |tr_hit;
  assign alloc  = tr_valid_i && !tr_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i]    <= 1'b0;
        tag_q[i]    <= '0;
        last_q[i]   <= '0;
        stride_q[i] <= '0;
        conf_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (tr_valid_i && tr_hit[i]) begin
          stride_q[i] <= tr_addr_i - last_q[i];
          last_q[i]   <= tr_addr_i;
          conf_q[i]   <= conf_step(conf_q[i], (tr_addr_i - last_q[i]) == stride_q[i]);
        end else if (alloc && (rr_q == IDX_W'(i))) begin
          vld_q[i]    <= 1'b1;
          tag_q[i]    <= tr_pc_i;
          last_q[i]   <= tr_addr_i;
          stride_q[i] <= '0;
          conf_q[i]   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/spf_queue.sv
module spf_queue #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, tail_idx;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, dup, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign tail_idx = (wr_q == '0) ? PTR_W'(DEPTH - 1) : wr_q - PTR_W'(1);
  assign dup      = !empty && (mem_q[tail_idx] == data_i);
  assign do_push  = push_i && !full && !dup;
  assign do_pop   = pop_i && !empty;

  assign valid_o = !empty;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= ptr_inc(wr_q);
      end
      if (do_pop) rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spf_nl_fwd.sv
module spf_nl_fwd #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              miss_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      req_o <= fire_i && miss_i;
      if (fire_i && miss_i) addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned QDEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic              train_valid_i,
  input  logic [PC_W-1:0]   train_pc_i,
  input  logic [ADDR_W-1:0] train_addr_i,
  output logic              touch_valid_o,
  output logic [ADDR_W-1:0] touch_addr_o,
  input  logic              touch_ready_i,
  input  logic              touch_miss_i,
  output logic              nl_req_o,
  output logic [ADDR_W-1:0] nl_addr_o
);
  localparam int unsigned CNT_W = $clog2(QDEPTH + 1);

  logic              pf_fire;
  logic [ADDR_W-1:0] pf_addr;
  logic [CNT_W-1:0]  q_count;
  logic              touch_fire;

  spf_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_valid_i (fetch_valid_i),
    .lk_pc_i    (fetch_pc_i),
    .tr_valid_i (train_valid_i),
    .tr_pc_i    (train_pc_i),
    .tr_addr_i  (train_addr_i),
    .lk_fire_o  (pf_fire),
    .lk_addr_o  (pf_addr)
  );

  assign touch_fire = touch_valid_o && touch_ready_i;

  spf_queue #(
    .W(ADDR_W), .DEPTH(QDEPTH)
  ) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (pf_fire),
    .data_i  (pf_addr),
    .pop_i   (touch_fire),
    .valid_o (touch_valid_o),
    .data_o  (touch_addr_o),
    .count_o (q_count)
  );

  spf_nl_fwd #(
    .ADDR_W(ADDR_W)
  ) u_nl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (touch_fire),
    .miss_i (touch_miss_i),
    .addr_i (touch_addr_o),
    .req_o  (nl_req_o),
    .addr_o (nl_addr_o)
  );
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned QDEPTH = 4,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic              touch_valid_o,
  input logic [ADDR_W-1:0] touch_addr_o,
  input logic              touch_ready_i,
  input logic              touch_miss_i,
  input logic              nl_req_o,
  input logic [ADDR_W-1:0] nl_addr_o,
  input logic [CNT_W-1:0]  q_count
);
  always @(posedge clk_i) begin
    if (rst_ni) begin
      assert_no_overflow_R7: assert (q_count <= CNT_W'(QDEPTH));
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !touch_valid_o && !nl_req_o);

  assert_new_touch_after_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(touch_valid_o) |-> $past(fetch_valid_i));

  assert_hold_stalled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_valid_o && !touch_ready_i |=> touch_valid_o && $stable(touch_addr_o));

  assert_nl_from_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nl_req_o |-> $past(touch_valid_o && touch_ready_i && touch_miss_i));

  assert_nl_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nl_req_o |-> nl_addr_o == $past(touch_addr_o));
endmodule

bind stride_prefetcher stride_prefetcher_chk #(
  .ADDR_W(ADDR_W), .QDEPTH(QDEPTH), .CNT_W($clog2(QDEPTH + 1))
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .touch_valid_o (touch_valid_o),
  .touch_addr_o  (touch_addr_o),
  .touch_ready_i (touch_ready_i),
  .touch_miss_i  (touch_miss_i),
  .nl_req_o      (nl_req_o),
  .nl_addr_o     (nl_addr_o),
  .q_count       (q_count)
);

// File: tb/stride_prefetcher_bench.sv
module stride_prefetcher_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        train_valid_i = 1'b0;
  logic [31:0] train_pc_i = '0;
  logic [31:0] train_addr_i = '0;
  logic        touch_valid_o;
  logic [31:0] touch_addr_o;
  logic        touch_ready_i = 1'b0;
  logic        touch_miss_i = 1'b0;
  logic        nl_req_o;
  logic [31:0] nl_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  stride_prefetcher u_stride_prefetcher (
    .clk_i, .rst_ni, .fetch_valid_i, .fetch_pc_i, .train_valid_i, .train_pc_i,
    .train_addr_i, .touch_valid_o, .touch_addr_o, .touch_ready_i, .touch_miss_i,
    .nl_req_o, .nl_addr_o
  );

  localparam logic [31:0] P1 = 32'h100, P2 = 32'h200;

  // {train address, touch expected, expected touch address} for load P1
  localparam logic [64:0] VEC [9] = '{
    {32'h0000_1000, 1'b0, 32'h0},          // R5 allocate
    {32'h0000_1010, 1'b0, 32'h0},          // R4 new stride, conf 0
    {32'h0000_1020, 1'b0, 32'h0},          // R4 conf 1
    {32'h0000_1030, 1'b1, 32'h0000_1040},  // R4 conf 2 fires
    {32'h0000_1040, 1'b1, 32'h0000_1050},  // R4 conf 3
    {32'h0000_1044, 1'b1, 32'h0000_1048},  // R3 stride 4, conf 2
    {32'h0000_1000, 1'b0, 32'h0},          // R4 conf 1
    {32'h0000_0fbc, 1'b1, 32'h0000_0f78},  // R3 negative stride
    {32'h0000_0f78, 1'b1, 32'h0000_0f34}   // R3 R4 saturate
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] a);
    @(negedge clk_i);
    train_valid_i = 1'b1; train_pc_i = pc; train_addr_i = a;
    @(negedge clk_i);
    train_valid_i = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] pc);
    fetch_valid_i = 1'b1; fetch_pc_i = pc;
    @(negedge clk_i);
    fetch_valid_i = 1'b0;
  endtask

  task automatic pop_one();
    touch_ready_i = 1'b1;
    @(negedge clk_i);
    touch_ready_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(!touch_valid_o, "R1 touch idle in reset", 32'(touch_valid_o), 0);
    check(!nl_req_o, "R1 nl idle in reset", 32'(nl_req_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    fetch(P1);
    check(!touch_valid_o, "R1 empty table no prefetch", 32'(touch_valid_o), 0);

    foreach (VEC[i]) begin
      train(P1, VEC[i][64:33]);
      fetch(P1);
      check(touch_valid_o == VEC[i][32], $sformatf("R2 R4 vec%0d valid", i),
            32'(touch_valid_o), 32'(VEC[i][32]));
      if (VEC[i][32]) begin
        check(touch_addr_o == VEC[i][31:0], $sformatf("R2 R3 vec%0d addr", i),
              touch_addr_o, VEC[i][31:0]);
        pop_one();
        check(!touch_valid_o, "R6 popped", 32'(touch_valid_o), 0);
      end
    end

    // R8 same prediction twice: one entry only
    fetch_valid_i = 1'b1; fetch_pc_i = P1;
    @(negedge clk_i); @(negedge clk_i);
    fetch_valid_i = 1'b0;
    check(touch_addr_o == 32'h0f34, "R8 dup addr", touch_addr_o, 32'h0f34);
    pop_one();
    check(!touch_valid_o, "R8 dup suppressed", 32'(touch_valid_o), 0);

    // untrained address
    fetch(32'h0000_0300);
    check(!touch_valid_o, "R2 untrained no prefetch", 32'(touch_valid_o), 0);

    // R7 fill past depth with alternating predictions
    train(P2, 32'h8000); train(P2, 32'h8100); train(P2, 32'h8200); train(P2, 32'h8300);
    for (int k = 0; k < 6; k++) fetch((k % 2 == 0) ? P1 : P2);
    for (int k = 0; k < 4; k++) begin
      check(touch_valid_o, "R6 R7 queued", 32'(touch_valid_o), 1);
      check(touch_addr_o == ((k % 2 == 0) ? 32'h0f34 : 32'h8400), "R6 FIFO order R7",
            touch_addr_o, (k % 2 == 0) ? 32'h0f34 : 32'h8400);
      pop_one();
    end
    check(!touch_valid_o, "R7 extra prefetches dropped", 32'(touch_valid_o), 0);

    // R5 round robin: slots 2,3 then slot 0 (P1) evicted
    train(32'h300, 32'h10); train(32'h400, 32'h20); train(32'h500, 32'h30);
    fetch(P1);
    check(!touch_valid_o, "R5 evicted entry silent", 32'(touch_valid_o), 0);
    fetch(P2);
    check(touch_valid_o && touch_addr_o == 32'h8400, "R5 survivor fires", touch_addr_o, 32'h8400);

    // R6 hold while stalled
    @(negedge clk_i);
    check(touch_valid_o && touch_addr_o == 32'h8400, "R6 stall hold", touch_addr_o, 32'h8400);

    // R9 touch miss
    touch_ready_i = 1'b1; touch_miss_i = 1'b1;
    @(negedge clk_i);
    touch_ready_i = 1'b0; touch_miss_i = 1'b0;
    check(nl_req_o, "R9 miss request", 32'(nl_req_o), 1);
    check(nl_addr_o == 32'h8400, "R9 miss addr", nl_addr_o, 32'h8400);
    @(negedge clk_i);
    check(!nl_req_o, "R9 single pulse", 32'(nl_req_o), 0);

    // R9 touch hit
    fetch(P2);
    touch_ready_i = 1'b1; touch_miss_i = 1'b0;
    @(negedge clk_i);
    touch_ready_i = 1'b0;
    check(!nl_req_o, "R9 hit no request", 32'(nl_req_o), 0);
    check(!touch_valid_o, "R6 hit consumed", 32'(touch_valid_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule